// File: doc/BRIEF.md
# Flash Bus Control and Reset Unit

This block is the synchronous control front end of a parallel NOR-style flash device. It samples the active-low select, output-enable, write-strobe, reset and byte-width pins on the system clock, keeps track of which read view is active (array data, identifier codes or the status byte), and runs a busy window that stands in for a long program or erase. It produces the two output enables of a 16-bit tri-state data bus (low byte and high byte), an open-style ready/busy flag and the 8-bit status byte. The memory array and the real program algorithm are outside the block.

The device reset pin is qualified by a minimum low time, counted in clock cycles. A reset that meets the minimum forces the array view and the idle status value, aborts any running operation, and keeps ready/busy low until recovery. After such a reset is released, two independent windows run: one during which the data bus stays off, and a separate one during which command writes are dropped. A shorter reset pulse is not a reset at all. Two undervoltage inputs lock out every command write without affecting reads.

Top module: `nor_bus_ctrl`

## Requirements
- R1: After the power-on reset `por_n` is released, `rd_mode` is 0 (array), `status` is 0x80 and `ry_by` is 1.
- R2: With `rp_n` high and no wake-up window running, `dq_oe_lo` is 1 exactly when `ce_n` and `oe_n` are both 0; with `oe_n` at 1 both output enables are 0.
- R3: With `ce_n` at 1 (standby) both output enables are 0 whatever `oe_n` is.
- R4: With `byte_n` at 0 the high-byte enable `dq_oe_hi` is 0 while `dq_oe_lo` still follows R2; with `byte_n` at 1 `dq_oe_hi` equals `dq_oe_lo`.
- R5: A command is taken on a falling edge of `we_n` seen on the clock while `ce_n` is 0: `din` 0xFF selects array (`rd_mode` 0), 0x90 identifier (`rd_mode` 1), 0x70 status (`rd_mode` 2), 0x20 starts an operation; any other value changes nothing.
- R6: A started operation drives `ry_by` to 0, `status` to 0x00 and `rd_mode` to 2 for OP_CYC clock cycles, then returns `status` to 0x80 and `ry_by` to 1; it keeps running with `ce_n` at 1, and writes made while it runs are ignored.
- R7: While `rp_n` is 0 both output enables are 0; once `rp_n` has been sampled 0 on RST_MIN consecutive edges, `rd_mode` becomes 0 and `status` 0x80.
- R8: A valid reset during an operation aborts it, and `ry_by` stays 0 until the write-recovery window after release has ended, then returns to 1.
- R9: A reset pulse sampled low on fewer than RST_MIN edges changes neither `rd_mode` nor a running operation.
- R10: After a valid reset is released, both output enables stay 0 for WAKE_CYC clock cycles and then follow R2.
- R11: After a valid reset is released, command writes during the next WREC_CYC clock cycles are dropped; later writes are taken.
- R12: With `vcc_lock` or `vpp_lock` at 1 every command write is ignored, while output enabling per R2 still works with `vpp_lock` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; command taken on its falling edge |
| rp_n | input | 1 | Device reset pin, active low, minimum width RST_MIN cycles |
| byte_n | input | 1 | 0 selects 8-bit bus width, 1 selects 16-bit |
| vcc_lock | input | 1 | Supply undervoltage indication |
| vpp_lock | input | 1 | Program voltage undervoltage indication |
| din | input | 8 | Command byte |
| dq_oe_lo | output | 1 | Drive enable for data bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for data bits 15:8 |
| rd_mode | output | 2 | Active read view: 0 array, 1 identifier, 2 status |
| ry_by | output | 1 | 1 ready, 0 busy |
| status | output | 8 | Status byte: 0x80 idle, 0x00 busy |

## Verification
The bench targets the reset qualifier at its threshold: a pulse one cycle short of RST_MIN must leave the identifier view and a running operation untouched, where an off-by-one qualifier would abort the operation or snap back to the array view. It counts the wake-up and write-recovery windows edge by edge after release, so a design that opened the bus one cycle early, or that shared one counter for both windows, shows a driven bus or an accepted write at the wrong cycle. It aborts an operation and watches ready/busy stay low through recovery and not revive later, and it deselects the chip mid-operation to catch a design that stops the busy window on standby. Lockout is tested on each supply input alone, with reads confirmed still enabled under program-voltage lockout.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rmode_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ARRAY,
    CMD_IDENT,
    CMD_STAT,
    CMD_START
  } cmd_e;

  localparam logic [7:0] ST_IDLE = 8'h80;
  localparam logic [7:0] ST_BUSY = 8'h00;

  function automatic cmd_e decode_cmd(input logic [7:0] d);
    case (d)
      8'hFF:   decode_cmd = CMD_ARRAY;
      8'h90:   decode_cmd = CMD_IDENT;
      8'h70:   decode_cmd = CMD_STAT;
      8'h20:   decode_cmd = CMD_START;
      default: decode_cmd = CMD_NONE;
    endcase
  endfunction

  function automatic logic bus_drive(input logic ce_n, input logic oe_n,
                                     input logic awake);
    bus_drive = awake && !ce_n && !oe_n;
  endfunction

endpackage

// File: rtl/nbc_rst_seq.sv
module nbc_rst_seq #(
  parameter int RST_MIN  = 4,
  parameter int WAKE_CYC = 3,
  parameter int WREC_CYC = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic rp_n,
  output logic rst_hit,
  output logic awake,
  output logic wr_open,
  output logic wake_busy,
  output logic wrec_busy
);
  localparam int LW = $clog2(RST_MIN + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam int RW = $clog2(WREC_CYC + 1);

  logic [LW-1:0] lo_cnt;
  logic [WW-1:0] wake_cnt;
  logic [RW-1:0] wrec_cnt;
  logic          rel_valid;
  logic          settled;

  assign rst_hit   = !rp_n && (lo_cnt == LW'(RST_MIN - 1));
  assign rel_valid = rp_n && (lo_cnt == LW'(RST_MIN));
  assign settled   = rp_n && (lo_cnt == '0);
  assign wake_busy = (wake_cnt != '0);
  assign wrec_busy = (wrec_cnt != '0);
  assign awake     = settled && !wake_busy;
  assign wr_open   = settled && !wrec_busy;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lo_cnt <= '0;
    end else if (!rp_n) begin
      if (lo_cnt != LW'(RST_MIN)) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wake_cnt <= '0;
      wrec_cnt <= '0;
    end else if (!rp_n) begin
      wake_cnt <= '0;
      wrec_cnt <= '0;
    end else if (rel_valid) begin
      wake_cnt <= WW'(WAKE_CYC);
      wrec_cnt <= RW'(WREC_CYC);
    end else begin
      if (wake_busy) wake_cnt <= wake_cnt - 1'b1;
      if (wrec_busy) wrec_cnt <= wrec_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/nbc_cmd_ctl.sv
module nbc_cmd_ctl
  import nbc_pkg::*;
#(
  parameter int OP_CYC = 20
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_evt,
  input  logic [7:0] wr_data,
  input  logic       rst_hit,
  input  logic       recov_done,
  output rmode_e     mode,
  output logic       busy,
  output logic       abort_hold,
  output logic [7:0] status
);
  localparam int OW = $clog2(OP_CYC + 1);

  logic [OW-1:0] op_cnt;
  cmd_e          cmd;

  assign cmd = decode_cmd(wr_data);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode       <= RM_ARRAY;
      busy       <= 1'b0;
      abort_hold <= 1'b0;
      status     <= ST_IDLE;
      op_cnt     <= '0;
    end else if (rst_hit) begin
      mode       <= RM_ARRAY;
      status     <= ST_IDLE;
      abort_hold <= abort_hold | busy;
      busy       <= 1'b0;
      op_cnt     <= '0;
    end else begin
      if (abort_hold && recov_done) abort_hold <= 1'b0;
      if (busy) begin
        op_cnt <= op_cnt - 1'b1;
        if (op_cnt == OW'(1)) begin
          busy   <= 1'b0;
          status <= ST_IDLE;
        end
      end else if (wr_evt) begin
        case (cmd)
          CMD_ARRAY: mode <= RM_ARRAY;
          CMD_IDENT: mode <= RM_IDENT;
          CMD_STAT:  mode <= RM_STATUS;
          CMD_START: begin
            mode   <= RM_STATUS;
            busy   <= 1'b1;
            status <= ST_BUSY;
            op_cnt <= OW'(OP_CYC);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/nbc_out_gate.sv
module nbc_out_gate
  import nbc_pkg::*;
(
  input  logic ce_n,
  input  logic oe_n,
  input  logic byte_n,
  input  logic awake,
  output logic oe_lo,
  output logic oe_hi
);
  assign oe_lo = bus_drive(ce_n, oe_n, awake);
  assign oe_hi = oe_lo && byte_n;
endmodule

// File: rtl/nor_bus_ctrl.sv
module nor_bus_ctrl
  import nbc_pkg::*;
#(
  parameter int RST_MIN  = 4,
  parameter int WAKE_CYC = 3,
  parameter int WREC_CYC = 5,
  parameter int OP_CYC   = 20
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       rp_n,
  input  logic       byte_n,
  input  logic       vcc_lock,
  input  logic       vpp_lock,
  input  logic [7:0] din,
  output logic       dq_oe_lo,
  output logic       dq_oe_hi,
  output logic [1:0] rd_mode,
  output logic       ry_by,
  output logic [7:0] status
);
  logic   we_q;
  logic   we_fall;
  logic   wr_evt;
  logic   rst_hit;
  logic   awake;
  logic   wr_open;
  logic   wake_busy;
  logic   wrec_busy;
  logic   busy;
  logic   abort_hold;
  rmode_e mode;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign we_fall = we_q && !we_n;
  assign wr_evt  = we_fall && !ce_n && wr_open && !vcc_lock && !vpp_lock;

  nbc_rst_seq #(
    .RST_MIN (RST_MIN),
    .WAKE_CYC(WAKE_CYC),
    .WREC_CYC(WREC_CYC)
  ) u_rst (
    .clk      (clk),
    .por_n    (por_n),
    .rp_n     (rp_n),
    .rst_hit  (rst_hit),
    .awake    (awake),
    .wr_open  (wr_open),
    .wake_busy(wake_busy),
    .wrec_busy(wrec_busy)
  );

  nbc_cmd_ctl #(
    .OP_CYC(OP_CYC)
  ) u_cmd (
    .clk       (clk),
    .por_n     (por_n),
    .wr_evt    (wr_evt),
    .wr_data   (din),
    .rst_hit   (rst_hit),
    .recov_done(wr_open),
    .mode      (mode),
    .busy      (busy),
    .abort_hold(abort_hold),
    .status    (status)
  );

  nbc_out_gate u_gate (
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .byte_n(byte_n),
    .awake (awake),
    .oe_lo (dq_oe_lo),
    .oe_hi (dq_oe_hi)
  );

  assign rd_mode = mode;
  assign ry_by   = !(busy || abort_hold);

endmodule

// File: rtl/nbc_checker.sv
module nbc_checker (
  input logic       clk,
  input logic       por_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       rp_n,
  input logic       byte_n,
  input logic       vcc_lock,
  input logic       vpp_lock,
  input logic       dq_oe_lo,
  input logic       dq_oe_hi,
  input logic [1:0] rd_mode,
  input logic       ry_by,
  input logic [7:0] status,
  input logic       rst_hit,
  input logic       wake_busy,
  input logic       wrec_busy,
  input logic       busy
);
  AST_OE_OFF_HIZ: assert property (@(posedge clk) disable iff (!por_n)
    oe_n |-> !dq_oe_lo && !dq_oe_hi); // R2
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!por_n)
    ce_n |-> !dq_oe_lo && !dq_oe_hi); // R3
  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!por_n)
    !byte_n |-> !dq_oe_hi); // R4
  AST_RESET_HIZ: assert property (@(posedge clk) disable iff (!por_n)
    !rp_n |-> !dq_oe_lo && !dq_oe_hi); // R7
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!por_n)
    rst_hit |=> rd_mode == 2'd0 && status == 8'h80); // R7
  AST_ABORT_RYBY: assert property (@(posedge clk) disable iff (!por_n)
    rst_hit && busy |=> !ry_by && !busy); // R8
  AST_WAKE_HIZ: assert property (@(posedge clk) disable iff (!por_n)
    wake_busy |-> !dq_oe_lo); // R10
  AST_WREC_DROP: assert property (@(posedge clk) disable iff (!por_n)
    wrec_busy && rp_n && !busy |=> $stable(rd_mode) && !busy); // R11
  AST_LOCK_MODE: assert property (@(posedge clk) disable iff (!por_n)
    (vcc_lock || vpp_lock) && rp_n |=> $stable(rd_mode)); // R12
  AST_LOCK_NOSTART: assert property (@(posedge clk) disable iff (!por_n)
    (vcc_lock || vpp_lock) && !busy |=> !busy); // R12
endmodule

bind nor_bus_ctrl nbc_checker u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .rp_n     (rp_n),
  .byte_n   (byte_n),
  .vcc_lock (vcc_lock),
  .vpp_lock (vpp_lock),
  .dq_oe_lo (dq_oe_lo),
  .dq_oe_hi (dq_oe_hi),
  .rd_mode  (rd_mode),
  .ry_by    (ry_by),
  .status   (status),
  .rst_hit  (rst_hit),
  .wake_busy(wake_busy),
  .wrec_busy(wrec_busy),
  .busy     (busy)
);

// File: tb/tb_nor_bus_ctrl.sv
`timescale 1ns/1ps
module tb_nor_bus_ctrl;
  localparam int RST_MIN  = 4;
  localparam int WAKE_CYC = 3;
  localparam int WREC_CYC = 5;
  localparam int OP_CYC   = 20;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, byte_n = 1'b1;
  logic       vcc_lock = 1'b0, vpp_lock = 1'b0;
  logic [7:0] din = 8'h00;
  logic       dq_oe_lo, dq_oe_hi, ry_by;
  logic [1:0] rd_mode;
  logic [7:0] status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nor_bus_ctrl #(
    .RST_MIN(RST_MIN), .WAKE_CYC(WAKE_CYC), .WREC_CYC(WREC_CYC), .OP_CYC(OP_CYC)
  ) dut (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
    .byte_n(byte_n), .vcc_lock(vcc_lock), .vpp_lock(vpp_lock), .din(din),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .rd_mode(rd_mode), .ry_by(ry_by),
    .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] d);
    @(negedge clk);
    din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
  endtask

  // hold rp_n low for n sampling edges, release on a falling clock edge
  task automatic rp_pulse(input int n);
    @(negedge clk);
    rp_n = 1'b0;
    ce_n = 1'b0; oe_n = 1'b0;
    #1 chk("R7 bus off in reset", dq_oe_lo, 1'b0);
    repeat (n) @(negedge clk);
    rp_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_powerup();
    #1;
    chk("R1 mode", rd_mode, 2'd0);
    chk("R1 status", status, 8'h80);
    chk("R1 ry_by", ry_by, 1'b1);
    chk("R3 standby off", dq_oe_lo, 1'b0);
  endtask

  task automatic t_gating();
    @(negedge clk);
    ce_n = 0; oe_n = 0; byte_n = 1;
    #1 chk("R2 lo on", dq_oe_lo, 1'b1);
    chk("R4 hi on wide", dq_oe_hi, 1'b1);
    oe_n = 1;
    #1 chk("R2 oe off lo", dq_oe_lo, 1'b0);
    chk("R2 oe off hi", dq_oe_hi, 1'b0);
    ce_n = 1; oe_n = 0;
    #1 chk("R3 standby lo", dq_oe_lo, 1'b0);
    chk("R3 standby hi", dq_oe_hi, 1'b0);
    ce_n = 0; byte_n = 0;
    #1 chk("R4 byte lo", dq_oe_lo, 1'b1);
    chk("R4 byte hi off", dq_oe_hi, 1'b0);
    byte_n = 1;
  endtask

  task automatic t_modes();
    wr_cmd(8'h90); #1 chk("R5 ident", rd_mode, 2'd1);
    wr_cmd(8'h70); #1 chk("R5 status", rd_mode, 2'd2);
    wr_cmd(8'h55); #1 chk("R5 unknown ignored", rd_mode, 2'd2);
    wr_cmd(8'hFF); #1 chk("R5 array", rd_mode, 2'd0);
    @(negedge clk); ce_n = 1; din = 8'h90; we_n = 0;
    @(negedge clk); we_n = 1;
    #1 chk("R5 needs ce", rd_mode, 2'd0);
  endtask

  task automatic t_op();
    wr_cmd(8'h20);            // negedge k=1 of busy
    #1 chk("R6 ry_by busy", ry_by, 1'b0);
    chk("R6 status busy", status, 8'h00);
    chk("R6 mode status", rd_mode, 2'd2);
    wr_cmd(8'hFF);            // k=3
    #1 chk("R6 write during op ignored", rd_mode, 2'd2);
    ce_n = 1;
    idle(OP_CYC - 3);         // k=OP_CYC
    #1 chk("R6 still busy deselected", ry_by, 1'b0);
    idle(1);
    #1 chk("R6 ready after op", ry_by, 1'b1);
    chk("R6 status idle", status, 8'h80);
  endtask

  task automatic t_wake();
    wr_cmd(8'h90);
    rp_pulse(RST_MIN);
    for (int n = 1; n <= WAKE_CYC; n++) begin
      @(negedge clk);
      #1 chk("R10 bus off in wake", dq_oe_lo, 1'b0);
    end
    @(negedge clk);
    #1 chk("R10 bus on after wake", dq_oe_lo, 1'b1);
    chk("R7 mode array", rd_mode, 2'd0);
    chk("R7 status", status, 8'h80);
    idle(WREC_CYC);
  endtask

  task automatic t_wrec();
    rp_pulse(RST_MIN);
    wr_cmd(8'h90);            // falls at n=1
    #1 chk("R11 early write dropped", rd_mode, 2'd0);
    idle(WREC_CYC);
    wr_cmd(8'h90);
    #1 chk("R11 late write taken", rd_mode, 2'd1);
  endtask

  task automatic t_abort();
    wr_cmd(8'h20);
    idle(2);
    rp_pulse(RST_MIN);
    @(negedge clk);           // n=1
    #1 chk("R8 ry_by low after abort", ry_by, 1'b0);
    chk("R8 status", status, 8'h80);
    chk("R8 mode array", rd_mode, 2'd0);
    idle(WREC_CYC - 1);       // n=WREC
    #1 chk("R8 ry_by low in recovery", ry_by, 1'b0);
    idle(2);                  // n=WREC+2
    #1 chk("R8 ry_by back high", ry_by, 1'b1);
    idle(OP_CYC);
    #1 chk("R8 op not resumed", ry_by, 1'b1);
  endtask

  task automatic t_short();
    wr_cmd(8'h90);
    rp_pulse(RST_MIN - 1);
    idle(1);
    #1 chk("R9 mode kept", rd_mode, 2'd1);
    wr_cmd(8'h20);
    rp_pulse(RST_MIN - 1);
    idle(1);
    #1 chk("R9 op continues", ry_by, 1'b0);
    chk("R9 status busy", status, 8'h00);
    idle(OP_CYC);
    #1 chk("R9 op completes", ry_by, 1'b1);
    chk("R9 status idle", status, 8'h80);
  endtask

  task automatic t_lock();
    wr_cmd(8'hFF);
    vpp_lock = 1;
    wr_cmd(8'h90);
    #1 chk("R12 vpp blocks mode", rd_mode, 2'd0);
    wr_cmd(8'h20);
    #1 chk("R12 vpp blocks op", ry_by, 1'b1);
    oe_n = 0; ce_n = 0;
    #1 chk("R12 read under vpp lock", dq_oe_lo, 1'b1);
    vpp_lock = 0; vcc_lock = 1;
    wr_cmd(8'h90);
    #1 chk("R12 vcc blocks mode", rd_mode, 2'd0);
    vcc_lock = 0;
    wr_cmd(8'h90);
    #1 chk("R12 unlocked write", rd_mode, 2'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_powerup();
    t_gating();
    t_modes();
    t_op();
    t_wake();
    t_wrec();
    t_abort();
    t_short();
    t_lock();
    idle(2);
    finish_run();
  end

endmodule